// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block keeps wall-clock time as a plain 32-bit count of seconds. A prescaler counts reference clock cycles against a programmable frequency word. Each time the prescaler completes a full second, the seconds counter steps by one. Software reaches the block through a small 16-bit register bus with byte addresses at a 4-byte stride. Every 32-bit quantity is split into a low and a high half.

The live count is never read or written directly. To write it, software stages a value in the preset halves and raises a load request bit. To read it, software raises a capture request bit and reads the captured copy afterwards. Hardware clears both request bits once the transfer has happened, so software can poll them.

A 32-bit alarm value is compared with the count. Reaching the alarm value sets a pending flag, which drives a level-high interrupt line. Control bits can hide, force or drop that interrupt.

Top module: `sec_rtc`

## Requirements
- R1: Byte offsets are 0x00 control, 0x04/0x08 frequency word low/high, 0x0C/0x10 preset low/high, 0x14/0x18 alarm low/high, and 0x20/0x24 captured count low/high. The frequency, preset and alarm halves read back what was written. The captured halves ignore writes. Unmapped offsets read 0. Writing any storage half never changes the live count.
- R2: After reset the control register reads 0, the frequency word holds the reset parameter (12,000,000 by default, so the halves read 0x1B00 and 0x00B7), the other registers read 0 and the interrupt is low.
- R3: Control bit positions are: 0 run (active-low soft reset: 0 holds the prescaler at zero), 1 count enable, 2 wrap enable, 3 load request, 4 capture request, 5 interrupt mask, 6 interrupt force, 7 interrupt clear. Bit 7 always reads 0. Bits 15..8 read 0.
- R4: While bits 0 and 1 are both 1, the count rises by one each time the number of reference cycles in the frequency word has elapsed. A word of 0 or 1 gives a step every cycle. When either bit is 0, the count does not move.
- R5: A control write with bit 3 set copies the preset into the count on the following edge and restarts the prescaler. The next step comes a full frequency word of cycles after that edge. Bit 3 reads 0 afterwards.
- R6: A control write with bit 4 set copies the live count into the captured halves on the following edge. Bit 4 reads 0 afterwards.
- R7: A step from 0xFFFFFFFF gives 0 when bit 2 is 1. When bit 2 is 0, the count stays at 0xFFFFFFFF.
- R8: The edge on which the count becomes equal to the alarm value sets the pending flag on the next edge. The interrupt is high while the flag is set and bit 5 is 0.
- R9: Writing 1 to bit 7 drops the pending flag. The flag does not set again while the count stays equal to the alarm value.
- R10: Bit 5 set holds the interrupt low but keeps the pending flag, so clearing bit 5 raises the interrupt again.
- R11: Bit 6 set drives the interrupt high, regardless of the mask, the pending flag and bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level-high alarm interrupt |

## Verification
The counting path is tried with frequency words of 4 and 1, and preset values placed just below a half-word carry and at the all-ones top. These separate a correct divider from one that is off by one and a wrapping counter from a saturating one. Capture requests are placed 0, 2, 3 and 7 cycles after a load. These show whether the prescaler restarts on a load and whether the capture takes the current count or a stale one. The alarm is approached with the mask open and closed, then held equal after a clear. This separates edge capture from level capture and masking from clearing.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

   // register byte offsets; software decodes these
   localparam int OFS_CTL   = 'h00;
   localparam int OFS_FCW   = 'h04;
   localparam int OFS_PRE   = 'h0C;
   localparam int OFS_ALM   = 'h14;
   localparam int OFS_CAP   = 'h20;
   localparam int WORD_STEP = 4;

   // control bit positions
   localparam int B_RUN   = 0;
   localparam int B_CEN   = 1;
   localparam int B_WRAP  = 2;
   localparam int B_LOAD  = 3;
   localparam int B_CAPT  = 4;
   localparam int B_MASK  = 5;
   localparam int B_FRC   = 6;
   localparam int B_CLR   = 7;
   localparam int CTL_STORED = 7;

   typedef struct packed {
      logic frc;
      logic mask;
      logic capt;
      logic load;
      logic wrap;
      logic cen;
      logic run;
   } ctl_bits_t;

endpackage

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs
   import sec_rtc_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned CNT_W  = 32,
   parameter logic [CNT_W-1:0] FCW_RESET = CNT_W'(12_000_000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  live_count,
   output ctl_bits_t         ctl,
   output logic [CNT_W-1:0]  fcw,
   output logic [CNT_W-1:0]  preset,
   output logic [CNT_W-1:0]  alarm,
   output logic [CNT_W-1:0]  captured,
   output logic              clr_req
);

   localparam int NWORD = CNT_W / DATA_W;

   logic [CTL_STORED-1:0] ctl_q;
   logic                  ctl_hit;

   assign ctl_hit = bus_we && (bus_addr == ADDR_W'(OFS_CTL));
   assign clr_req = ctl_hit && bus_wdata[B_CLR];
   assign ctl     = ctl_bits_t'(ctl_q);

   // control: a bus write replaces the stored bits; otherwise the two
   // request bits fall back to 0 one edge after they were seen high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_hit) begin
         ctl_q <= bus_wdata[CTL_STORED-1:0];
      end else begin
         ctl_q[B_LOAD] <= 1'b0;
         ctl_q[B_CAPT] <= 1'b0;
      end
   end

   // captured count, filled only by the capture request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         captured <= '0;
      end else if (ctl_q[B_CAPT]) begin
         captured <= live_count;
      end
   end

   // multi-word storage registers, one half per generated slice
   for (genvar w = 0; w < NWORD; w++) begin : g_word
      logic [DATA_W-1:0] fcw_h;
      logic [DATA_W-1:0] pre_h;
      logic [DATA_W-1:0] alm_h;
      logic              fcw_hit;
      logic              pre_hit;
      logic              alm_hit;

      assign fcw_hit = bus_we && (bus_addr == ADDR_W'(OFS_FCW + WORD_STEP * w));
      assign pre_hit = bus_we && (bus_addr == ADDR_W'(OFS_PRE + WORD_STEP * w));
      assign alm_hit = bus_we && (bus_addr == ADDR_W'(OFS_ALM + WORD_STEP * w));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fcw_h <= FCW_RESET[w*DATA_W +: DATA_W];
            pre_h <= '0;
            alm_h <= '0;
         end else begin
            if (fcw_hit) fcw_h <= bus_wdata;
            if (pre_hit) pre_h <= bus_wdata;
            if (alm_hit) alm_h <= bus_wdata;
         end
      end

      assign fcw[w*DATA_W +: DATA_W]    = fcw_h;
      assign preset[w*DATA_W +: DATA_W] = pre_h;
      assign alarm[w*DATA_W +: DATA_W]  = alm_h;
   end

   // read multiplexer
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTL)) begin
         bus_rdata = DATA_W'(ctl_q);
      end
      for (int w = 0; w < NWORD; w++) begin
         if (bus_addr == ADDR_W'(OFS_FCW + WORD_STEP * w)) bus_rdata = fcw[w*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(OFS_PRE + WORD_STEP * w)) bus_rdata = preset[w*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(OFS_ALM + WORD_STEP * w)) bus_rdata = alarm[w*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(OFS_CAP + WORD_STEP * w)) bus_rdata = captured[w*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/sec_rtc_presc.sv
module sec_rtc_presc #(
   parameter int unsigned PRE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             advance,
   input  logic             restart,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);

   logic [PRE_W-1:0] cyc_q;
   logic [PRE_W:0]   cyc_nxt;

   assign cyc_nxt = {1'b0, cyc_q} + 1'b1;
   // a limit of 0 behaves like 1: every enabled cycle completes a second
   assign tick = advance && !hold && !restart && (cyc_nxt >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
      end else if (hold || restart) begin
         cyc_q <= '0;
      end else if (advance) begin
         cyc_q <= tick ? '0 : cyc_nxt[PRE_W-1:0];
      end
   end

endmodule

// File: rtl/sec_rtc_count.sv
module sec_rtc_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             wrap,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (tick) begin
         if (count != TOP || wrap) begin
            count <= count + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sec_rtc_alarm.sv
module sec_rtc_alarm #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] alarm,
   input  logic             mask,
   input  logic             frc,
   input  logic             clr,
   output logic             pend,
   output logic             irq
);

   logic equal;
   logic equal_q;

   assign equal = (count == alarm);

   // equal_q starts high so the reset state (both zero) is not an event
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         equal_q <= 1'b1;
         pend    <= 1'b0;
      end else begin
         equal_q <= equal;
         if (equal && !equal_q) begin
            pend <= 1'b1;
         end else if (clr) begin
            pend <= 1'b0;
         end
      end
   end

   assign irq = (pend && !mask) || frc;

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
   import sec_rtc_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned CNT_W  = 32,
   parameter logic [CNT_W-1:0] FCW_RESET = CNT_W'(12_000_000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   // elaboration checks on the parameter set
   if (CNT_W != 2 * DATA_W) begin : g_bad_split
      $error("sec_rtc: CNT_W must be two bus words");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("sec_rtc: DATA_W must hold the control bits");
   end
   if ((1 << ADDR_W) <= OFS_CAP + WORD_STEP) begin : g_bad_addr
      $error("sec_rtc: ADDR_W too narrow for the register map");
   end

   ctl_bits_t        ctl;
   logic [CNT_W-1:0] fcw;
   logic [CNT_W-1:0] preset;
   logic [CNT_W-1:0] alarm;
   logic [CNT_W-1:0] captured;
   logic [CNT_W-1:0] count_q;
   logic             clr_req;
   logic             tick;
   logic             pend;

   sec_rtc_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FCW_RESET(FCW_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .live_count(count_q), .ctl(ctl), .fcw(fcw), .preset(preset), .alarm(alarm),
      .captured(captured), .clr_req(clr_req)
   );

   sec_rtc_presc #(.PRE_W(CNT_W)) u_presc (
      .clk(clk), .rst_n(rst_n),
      .hold(!ctl.run), .advance(ctl.cen), .restart(ctl.load),
      .limit(fcw), .tick(tick)
   );

   sec_rtc_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n),
      .load(ctl.load), .load_val(preset), .tick(tick), .wrap(ctl.wrap),
      .count(count_q)
   );

   sec_rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
      .clk(clk), .rst_n(rst_n),
      .count(count_q), .alarm(alarm), .mask(ctl.mask), .frc(ctl.frc), .clr(clr_req),
      .pend(pend), .irq(irq)
   );

endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
   import sec_rtc_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input ctl_bits_t        ctl,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] preset,
   input logic [CNT_W-1:0] alarm,
   input logic [CNT_W-1:0] captured,
   input logic             pend,
   input logic             irq
);

   localparam logic [CNT_W-1:0] TOP = '1;

   p_load_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.load |=> count == $past(preset));

   p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.capt |=> captured == $past(count));

   p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.load |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

   p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.load && (!ctl.cen || !ctl.run)) |=> count == $past(count));

   p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.load && !ctl.wrap && count == TOP) |=> count == TOP);

   p_match_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(count == alarm) |=> pend);

   p_mask_hides_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.mask && !ctl.frc) |-> !irq);

   p_force_raises_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.frc |-> irq);

endmodule

bind sec_rtc sec_rtc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl(ctl), .count(count_q), .preset(preset),
   .alarm(alarm), .captured(captured), .pend(pend), .irq(irq)
);

// File: tb/sec_rtc_test.sv
`timescale 1ns/1ps
module sec_rtc_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sec_rtc uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam logic [5:0] A_CTL = 6'h00, A_FCWL = 6'h04, A_FCWH = 6'h08,
                          A_PREL = 6'h0C, A_PREH = 6'h10, A_ALML = 6'h14,
                          A_ALMH = 6'h18, A_CAPL = 6'h20, A_CAPH = 6'h24;

   // {address, write data, expected read-back}
   localparam logic [37:0] TBL [10] = '{
      {6'h04, 16'h0004, 16'h0004},
      {6'h08, 16'h0000, 16'h0000},
      {6'h0C, 16'h1234, 16'h1234},
      {6'h10, 16'hABCD, 16'hABCD},
      {6'h14, 16'h5555, 16'h5555},
      {6'h18, 16'hAAAA, 16'hAAAA},
      {6'h20, 16'hFFFF, 16'h0000},
      {6'h24, 16'hFFFF, 16'h0000},
      {6'h1C, 16'hFFFF, 16'h0000},
      {6'h00, 16'hFFA0, 16'h0020}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_cnt(input logic [15:0] keep, input logic [31:0] v);
      wr(A_PREL, v[15:0]);
      wr(A_PREH, v[31:16]);
      wr(A_CTL, keep | 16'h0008);
      idle(1);
   endtask

   task automatic capture(input logic [15:0] keep, output logic [31:0] v);
      logic [15:0] lo, hi;
      wr(A_CTL, keep | 16'h0010);
      idle(1);
      rd(A_CAPL, lo);
      rd(A_CAPH, hi);
      v = {hi, lo};
   endtask

   initial begin
      logic [15:0] d;
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R2 reset state
      rd(A_CTL, d);  check("R2 ctl", 32'(d), 32'h0);
      rd(A_FCWL, d); check("R2 fcw low", 32'(d), 32'h1B00);
      rd(A_FCWH, d); check("R2 fcw high", 32'(d), 32'h00B7);
      rd(A_CAPL, d); check("R2 captured", 32'(d), 32'h0);
      check("R2 irq", 32'(irq), 32'h0);

      // R1 / R3 register map walk
      for (int i = 0; i < 10; i++) begin
         wr(TBL[i][37:32], TBL[i][31:16]);
         rd(TBL[i][37:32], d);
         check("R1/R3 map", 32'(d), 32'(TBL[i][15:0]));
      end
      capture(16'h0020, v);
      check("R1 storage writes leave count", v, 32'h0);

      // R4 / R5 / R6 with a frequency word of 4
      wr(A_FCWL, 16'h0004);
      load_cnt(16'h0003, 32'h0000_FFFF);
      rd(A_CTL, d); check("R5 load bit self-clears", 32'(d[3]), 32'h0);
      idle(7);
      capture(16'h0003, v);
      check("R4 two seconds over half carry", v, 32'h0001_0001);
      rd(A_CTL, d); check("R6 capture bit self-clears", 32'(d[4]), 32'h0);
      load_cnt(16'h0003, 32'h0000_0100);
      capture(16'h0003, v);
      check("R6 capture right after load", v, 32'h0000_0100);
      idle(1);
      load_cnt(16'h0003, 32'h0000_0200);
      idle(2);
      capture(16'h0003, v);
      check("R5 prescaler restarts on load", v, 32'h0000_0200);
      load_cnt(16'h0003, 32'h0000_0300);
      idle(3);
      capture(16'h0003, v);
      check("R5 first step one second after load", v, 32'h0000_0301);

      // R4 enables
      load_cnt(16'h0001, 32'h0000_0500);
      idle(10);
      capture(16'h0001, v);
      check("R4 count enable off", v, 32'h0000_0500);
      load_cnt(16'h0002, 32'h0000_0600);
      idle(10);
      capture(16'h0002, v);
      check("R4 soft reset holds", v, 32'h0000_0600);

      // R4 / R7 with a frequency word of 1
      wr(A_FCWL, 16'h0001);
      load_cnt(16'h0003, 32'h0000_0010);
      idle(4);
      capture(16'h0003, v);
      check("R4 every cycle", v, 32'h0000_0015);
      load_cnt(16'h0007, 32'hFFFF_FFFF);
      capture(16'h0007, v);
      check("R7 wrap to zero", v, 32'h0000_0000);
      load_cnt(16'h0003, 32'hFFFF_FFFF);
      idle(5);
      capture(16'h0003, v);
      check("R7 saturate at top", v, 32'hFFFF_FFFF);

      // R8 / R9 alarm with a frequency word of 4
      wr(A_FCWL, 16'h0004);
      wr(A_ALML, 16'h2002);
      wr(A_ALMH, 16'h0000);
      wr(A_CTL, 16'h0083);
      check("R9 clear before test", 32'(irq), 32'h0);
      load_cnt(16'h0003, 32'h0000_2000);
      idle(8);
      check("R8 not yet on equal cycle", 32'(irq), 32'h0);
      idle(1);
      check("R8 raised one cycle after match", 32'(irq), 32'h1);
      wr(A_CTL, 16'h0001);
      check("R8 level holds", 32'(irq), 32'h1);
      wr(A_CTL, 16'h0081);
      idle(5);
      check("R9 no re-raise while equal", 32'(irq), 32'h0);
      capture(16'h0001, v);
      check("R9 count still equal", v, 32'h0000_2002);

      // R10 mask keeps pending
      load_cnt(16'h0023, 32'h0000_2001);
      idle(8);
      check("R10 masked", 32'(irq), 32'h0);
      wr(A_CTL, 16'h0001);
      check("R10 unmask shows pending", 32'(irq), 32'h1);
      wr(A_CTL, 16'h0081);
      check("R9 clear drops", 32'(irq), 32'h0);

      // R11 force
      wr(A_CTL, 16'h0041);
      check("R11 force", 32'(irq), 32'h1);
      rd(A_CTL, d); check("R11 force reads back", 32'(d), 32'h0041);
      wr(A_CTL, 16'h00E1);
      check("R11 force beats mask and clear", 32'(irq), 32'h1);
      wr(A_CTL, 16'h0001);
      check("R11 release", 32'(irq), 32'h0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5 * 20000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule